// File: doc/BRIEF.md
# Chip Erase Sequencer

This block runs the complete bulk-erase procedure for a byte-wide flash array from the host side. A single `start_i` pulse begins the job. The sequencer first walks every address and hands each one to an external byte-program sequencer, so that the whole array holds 0x00. It then drives erase pulses and a byte-by-byte verify loop through a request/acknowledge bus port. That port carries single writes of a command byte with an address, and single reads. All waiting is timed by internal counters.

When a verified byte does not read back as 0xFF, the sequencer keeps that address and applies one more erase pulse. Checking then continues from the kept byte rather than from address zero. Erase pulses are counted against a limit. The job ends with a one-cycle `done_o` pulse and a held pass or fail flag. A successful run first writes the read-mode command.

Top module: `chip_erase_seq`

## Requirements
- R1: After `start_i`, every address from 0 to 2^ADDR_W-1 is handed to the byte-program port (`pgm_start_o` pulse, data 0x00) in ascending order, and no bus request is raised until all of them have completed.
- R2: If the byte-program port reports failure (`pgm_fail_i` with `pgm_done_i`), the run ends with fail and no bus request of any kind is issued.
- R3: An erase pulse is two bus writes of 0x20, followed by exactly ERASE_WAIT clock cycles with no bus request.
- R4: A verify step is a bus write of 0xA0 carrying the byte address, then exactly VERIFY_WAIT cycles with no request, then a bus read of that same address; read data 0xFF means the byte is erased.
- R5: The first verify after the first erase pulse targets address 0, and each erased byte advances the verify address by one, up to 2^ADDR_W-1.
- R6: A byte that does not read 0xFF triggers another erase pulse, after which verification resumes at that same address; already verified bytes are not read again.
- R7: At most PULSE_LIMIT erase pulses are issued; a mismatch seen after the PULSE_LIMIT-th pulse ends the run with fail and no read-mode write.
- R8: When the last address reads 0xFF, a bus write of 0x00 is issued, and the run then ends with pass.
- R9: `done_o` is a one-cycle pulse at the end of each run; exactly one of `pass_o` and `fail_o` is high from that cycle until the next `start_i`.
- R10: While `bus_req_o` is high and `bus_ack_i` is low, the request and its direction, address and data stay unchanged in the next cycle.
- R11: After reset, `busy_o`, `done_o`, `pass_o`, `fail_o`, `bus_req_o` and `pgm_start_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a full erase run (taken when idle) |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| pass_o | output | 1 | Last run succeeded |
| fail_o | output | 1 | Last run failed |
| pgm_start_o | output | 1 | Start byte program of one address |
| pgm_addr_o | output | ADDR_W | Address to program |
| pgm_data_o | output | DATA_W | Data to program (always 0x00) |
| pgm_done_i | input | 1 | Byte program finished |
| pgm_fail_i | input | 1 | Byte program failed (valid with pgm_done_i) |
| bus_req_o | output | 1 | Bus cycle request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | ADDR_W | Bus cycle address |
| bus_wdata_o | output | DATA_W | Command byte for writes |
| bus_ack_i | input | 1 | Bus cycle completed |
| bus_rdata_i | input | DATA_W | Read data, valid with bus_ack_i |

## Verification
The bench models the array as a per-byte count of erase pulses needed before it reads 0xFF. It then sweeps every byte of a 16-byte configuration under several needs patterns. The corner cases it targets are these: a failure on byte 0, a failure on the last byte, a maximum need equal to the pulse limit, and a need one above it. It also injects a pre-program failure in mid-array. A design that restarted from address zero would show extra verify reads and a wrong verify address. A design off by one on the limit would pass the over-limit case or fail the boundary case. Wrong wait counters show up as idle gaps of the wrong length after the second erase write and after the verify command.

// File: rtl/ces_pkg.sv
package ces_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_PRE_GO, S_PRE_WAIT, S_ER_A, S_ER_B, S_ER_WAIT,
    S_VF_CMD, S_VF_WAIT, S_VF_RD, S_RD_CMD, S_END
  } ces_state_e;

  localparam logic [7:0] CMD_ERASE  = 8'h20;
  localparam logic [7:0] CMD_VERIFY = 8'hA0;
  localparam logic [7:0] CMD_READ   = 8'h00;
  localparam logic [7:0] BYTE_ERASED = 8'hFF;
  localparam logic [7:0] BYTE_ZERO  = 8'h00;
endpackage

// File: rtl/ces_wait_timer.sv
module ces_wait_timer #(
  parameter int unsigned TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] len_i,
  output logic          expired_o
);
  logic [TW-1:0] cnt_q;

  // load len-1 so the wait state lasts exactly len cycles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= len_i - TW'(1);
    else if (cnt_q != '0)   cnt_q <= cnt_q - TW'(1);
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/ces_addr_ctr.sv
module ces_addr_ctr #(
  parameter int unsigned AW = 17
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      addr_q <= '0;
    else if (clr_i)   addr_q <= '0;
    else if (inc_i)   addr_q <= addr_q + AW'(1);
  end

  assign addr_o = addr_q;
  assign last_o = &addr_q;

  // R5/R6: address only moves forward between clears (resume, never restart)
  a_r6_no_backstep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> addr_q >= $past(addr_q));
endmodule

// File: rtl/ces_pulse_ctr.sv
module ces_pulse_ctr #(
  parameter int unsigned LIMIT = 1000,
  localparam int unsigned PW = $clog2(LIMIT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [PW-1:0] count_o,
  output logic          at_limit_o
);
  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (inc_i)   cnt_q <= cnt_q + PW'(1);
  end

  assign count_o    = cnt_q;
  assign at_limit_o = (cnt_q == PW'(LIMIT));

  a_r7_within_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= PW'(LIMIT));
  a_r7_no_inc_at_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |-> !at_limit_o);
endmodule

// File: rtl/chip_erase_seq.sv
module chip_erase_seq
  import ces_pkg::*;
#(
  parameter int unsigned ADDR_W      = 17,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned PULSE_LIMIT = 1000,
  parameter int unsigned ERASE_WAIT  = 500000,
  parameter int unsigned VERIFY_WAIT = 300
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o,
  output logic              fail_o,
  output logic              pgm_start_o,
  output logic [ADDR_W-1:0] pgm_addr_o,
  output logic [DATA_W-1:0] pgm_data_o,
  input  logic              pgm_done_i,
  input  logic              pgm_fail_i,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic              bus_ack_i,
  input  logic [DATA_W-1:0] bus_rdata_i
);
  localparam int unsigned WMAX = (ERASE_WAIT > VERIFY_WAIT) ? ERASE_WAIT : VERIFY_WAIT;
  localparam int unsigned TW   = $clog2(WMAX + 1);
  localparam int unsigned PW   = $clog2(PULSE_LIMIT + 1);

  ces_state_e state_q, state_d;
  logic [ADDR_W-1:0] addr;
  logic addr_last, addr_clr, addr_inc;
  logic pulse_clr, pulse_inc, pulse_at_limit;
  logic [PW-1:0] pulse_cnt;
  logic tmr_load, tmr_expired;
  logic [TW-1:0] tmr_len;
  logic pass_q, fail_q, set_pass, set_fail, clr_res;
  logic ack;

  assign ack = bus_req_o & bus_ack_i;

  ces_addr_ctr #(.AW(ADDR_W)) u_addr (
    .clk_i, .rst_ni, .clr_i(addr_clr), .inc_i(addr_inc),
    .addr_o(addr), .last_o(addr_last)
  );

  ces_pulse_ctr #(.LIMIT(PULSE_LIMIT)) u_pulse (
    .clk_i, .rst_ni, .clr_i(pulse_clr), .inc_i(pulse_inc),
    .count_o(pulse_cnt), .at_limit_o(pulse_at_limit)
  );

  ces_wait_timer #(.TW(TW)) u_tmr (
    .clk_i, .rst_ni, .load_i(tmr_load), .len_i(tmr_len), .expired_o(tmr_expired)
  );

  assign tmr_len = (state_q == S_ER_B) ? TW'(ERASE_WAIT) : TW'(VERIFY_WAIT);

  always_comb begin
    state_d   = state_q;
    addr_clr  = 1'b0;
    addr_inc  = 1'b0;
    pulse_clr = 1'b0;
    pulse_inc = 1'b0;
    tmr_load  = 1'b0;
    set_pass  = 1'b0;
    set_fail  = 1'b0;
    clr_res   = 1'b0;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        addr_clr  = 1'b1;
        pulse_clr = 1'b1;
        clr_res   = 1'b1;
        state_d   = S_PRE_GO;
      end
      S_PRE_GO: state_d = S_PRE_WAIT;
      S_PRE_WAIT: if (pgm_done_i) begin
        if (pgm_fail_i) begin
          set_fail = 1'b1;
          state_d  = S_END;
        end else if (addr_last) begin
          addr_clr = 1'b1;
          state_d  = S_ER_A;
        end else begin
          addr_inc = 1'b1;
          state_d  = S_PRE_GO;
        end
      end
      S_ER_A: if (ack) state_d = S_ER_B;
      S_ER_B: if (ack) begin
        pulse_inc = 1'b1;
        tmr_load  = 1'b1;
        state_d   = S_ER_WAIT;
      end
      S_ER_WAIT: if (tmr_expired) state_d = S_VF_CMD;
      S_VF_CMD: if (ack) begin
        tmr_load = 1'b1;
        state_d  = S_VF_WAIT;
      end
      S_VF_WAIT: if (tmr_expired) state_d = S_VF_RD;
      S_VF_RD: if (ack) begin
        if (bus_rdata_i == DATA_W'(BYTE_ERASED)) begin
          if (addr_last) state_d = S_RD_CMD;
          else begin
            addr_inc = 1'b1;
            state_d  = S_VF_CMD;
          end
        end else if (pulse_at_limit) begin
          set_fail = 1'b1;
          state_d  = S_END;
        end else begin
          state_d = S_ER_A;  // keep addr, re-erase, resume here
        end
      end
      S_RD_CMD: if (ack) begin
        set_pass = 1'b1;
        state_d  = S_END;
      end
      S_END:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      pass_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (clr_res) begin
        pass_q <= 1'b0;
        fail_q <= 1'b0;
      end else begin
        if (set_pass) pass_q <= 1'b1;
        if (set_fail) fail_q <= 1'b1;
      end
    end
  end

  always_comb begin
    bus_req_o   = 1'b0;
    bus_we_o    = 1'b1;
    bus_wdata_o = DATA_W'(CMD_READ);
    unique case (state_q)
      S_ER_A, S_ER_B: begin bus_req_o = 1'b1; bus_wdata_o = DATA_W'(CMD_ERASE);  end
      S_VF_CMD:       begin bus_req_o = 1'b1; bus_wdata_o = DATA_W'(CMD_VERIFY); end
      S_VF_RD:        begin bus_req_o = 1'b1; bus_we_o = 1'b0; end
      S_RD_CMD:       begin bus_req_o = 1'b1; bus_wdata_o = DATA_W'(CMD_READ);   end
      default: ;
    endcase
  end

  assign bus_addr_o  = addr;
  assign pgm_start_o = (state_q == S_PRE_GO);
  assign pgm_addr_o  = addr;
  assign pgm_data_o  = DATA_W'(BYTE_ZERO);
  assign busy_o      = (state_q != S_IDLE);
  assign done_o      = (state_q == S_END);
  assign pass_o      = pass_q;
  assign fail_o      = fail_q;

  a_r10_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_addr_o)
                                   && $stable(bus_we_o) && $stable(bus_wdata_o)));
  a_r9_one_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (pass_o ^ fail_o));
  a_r8_pass_after_read_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pass_o) |-> $past(bus_ack_i && bus_req_o && bus_we_o
                            && bus_wdata_o == DATA_W'(CMD_READ)));
  a_r1_no_bus_during_pgm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pgm_start_o |=> !bus_req_o);
endmodule

// File: tb/chip_erase_seq_bench.sv
module chip_erase_seq_bench;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int NB = 1 << AW;
  localparam int LIM = 6;
  localparam int EW = 20;
  localparam int VW = 5;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic busy, done, pass, fail, pgm_start, pgm_done = 1'b0, pgm_fail = 1'b0;
  logic [AW-1:0] pgm_addr, bus_addr;
  logic [DW-1:0] pgm_data, bus_wdata, bus_rdata = '0;
  logic bus_req, bus_we, bus_ack = 1'b0;

  chip_erase_seq #(.ADDR_W(AW), .DATA_W(DW), .PULSE_LIMIT(LIM),
                   .ERASE_WAIT(EW), .VERIFY_WAIT(VW)) u_chip_erase_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .busy_o(busy), .done_o(done),
    .pass_o(pass), .fail_o(fail), .pgm_start_o(pgm_start), .pgm_addr_o(pgm_addr),
    .pgm_data_o(pgm_data), .pgm_done_i(pgm_done), .pgm_fail_i(pgm_fail),
    .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_addr_o(bus_addr),
    .bus_wdata_o(bus_wdata), .bus_ack_i(bus_ack), .bus_rdata_i(bus_rdata)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0, cycles = 0;
  int need [NB];
  int fail_at = -1;
  int pgm_cnt, pgm_cd, pgm_cur, er_writes, pulses, exp_v, v_addr, vreads, run_len, prev_kind;
  bit saw_rd_cmd;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        chk(1'b0, "R9 watchdog", cycles, 150000);
        finish_run();
      end
    end
  end

  // prev_kind: 0 none, 1 first erase write, 2 second erase write, 3 verify cmd, 4 read, 5 read cmd
  initial begin
    forever begin
      @(negedge clk);
      if (!bus_req) run_len++;
      if (pgm_done) begin
        pgm_done = 1'b0;
        pgm_fail = 1'b0;
      end else if (pgm_cd > 0) begin
        pgm_cd--;
        if (pgm_cd == 0) begin
          pgm_done = 1'b1;
          pgm_fail = (pgm_cur == fail_at);
        end
      end
      if (pgm_start) begin
        chk(int'(pgm_addr) == pgm_cnt, "R1 pgm address order", pgm_addr, pgm_cnt);
        chk(pgm_data == 8'h00, "R1 pgm data", pgm_data, 0);
        pgm_cur = pgm_addr;
        pgm_cnt++;
        pgm_cd = 3;
      end
      if (bus_ack) begin
        bus_ack = 1'b0;
      end else if (bus_req) begin
        bus_ack = 1'b1;
        chk(pgm_cnt == NB && pgm_cd == 0 && fail_at < 0, "R1 R2 bus before pgm done", pgm_cnt, NB);
        if (prev_kind == 2) chk(run_len == EW, "R3 erase wait", run_len, EW);
        if (bus_we && bus_wdata == 8'h20) begin
          er_writes++;
          if (er_writes % 2 == 0) begin
            pulses++;
            prev_kind = 2;
          end else prev_kind = 1;
        end else if (bus_we && bus_wdata == 8'hA0) begin
          chk(prev_kind == 2 || prev_kind == 4, "R4 verify order", prev_kind, 4);
          chk(int'(bus_addr) == exp_v, "R5 R6 verify address", bus_addr, exp_v);
          v_addr = bus_addr;
          prev_kind = 3;
        end else if (!bus_we) begin
          chk(prev_kind == 3 && int'(bus_addr) == v_addr, "R4 read address", bus_addr, v_addr);
          chk(run_len == VW, "R4 verify wait", run_len, VW);
          vreads++;
          if (pulses >= need[bus_addr]) begin
            bus_rdata = 8'hFF;
            exp_v++;
          end else bus_rdata = 8'h00;
          prev_kind = 4;
        end else if (bus_we && bus_wdata == 8'h00) begin
          chk(exp_v == NB, "R8 read cmd after last byte", exp_v, NB);
          saw_rd_cmd = 1'b1;
          prev_kind = 5;
        end else begin
          chk(1'b0, "R3 unexpected bus cycle", bus_wdata, 0);
        end
        run_len = 0;
      end
    end
  end

  task automatic run_case(input int mode, input int f_at);
    int mx, exp_pulses, exp_reads, wait_n;
    bit exp_pass;
    for (int a = 0; a < NB; a++) begin
      case (mode)
        0: need[a] = 1;
        1: need[a] = (a * 3) % 5 + 1;
        2: need[a] = (a == 9) ? LIM : (a % 3) + 1;
        3: need[a] = (a == 7) ? LIM + 1 : 1;
        4: need[a] = (a == 0) ? 2 : 1;
        default: need[a] = (a == NB - 1) ? 3 : 1;
      endcase
    end
    mx = 0;
    for (int a = 0; a < NB; a++) if (need[a] > mx) mx = need[a];
    fail_at = f_at;
    exp_pass = (f_at < 0) && (mx <= LIM);
    exp_pulses = (f_at >= 0) ? 0 : ((mx <= LIM) ? mx : LIM);
    exp_reads = NB + mx - 1;
    pgm_cnt = 0; pgm_cd = 0; er_writes = 0; pulses = 0; exp_v = 0; vreads = 0;
    run_len = 0; prev_kind = 0; saw_rd_cmd = 1'b0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_n = 0;
    while (!done && wait_n < 100000) begin
      @(negedge clk);
      wait_n++;
    end
    chk(done, "R9 done seen", done, 1);
    chk(pass == exp_pass && fail == !exp_pass, "R7 R8 R2 result", pass, exp_pass);
    chk(pulses == exp_pulses, "R7 pulse count", pulses, exp_pulses);
    chk(saw_rd_cmd == exp_pass, "R8 read cmd issued", saw_rd_cmd, exp_pass);
    if (f_at >= 0) chk(pgm_cnt == f_at + 1, "R2 pgm stop", pgm_cnt, f_at + 1);
    else chk(pgm_cnt == NB, "R1 pgm count", pgm_cnt, NB);
    if (exp_pass) chk(vreads == exp_reads, "R6 no re-read", vreads, exp_reads);
    @(negedge clk);
    chk(!done && !busy, "R9 done one cycle", done, 0);
    chk(pass == exp_pass && fail == !exp_pass, "R9 result held", pass, exp_pass);
    fail_at = -1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !pass && !fail && !bus_req && !pgm_start, "R11 reset state",
        {busy, done, pass, fail, bus_req, pgm_start}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !bus_req, "R11 idle after reset", busy, 0);
    for (int m = 0; m < 6; m++) run_case(m, -1);
    run_case(0, 5);
    run_case(1, -1);
    finish_run();
  end
endmodule